// File: doc/BRIEF.md
# Programmable Line-Timed IRQ Generator

The block raises an interrupt request at a CPU cycle worked out from a video line number that software programs. A free-running cycle counter restarts on every frame-start pulse. When software writes a line number N to the target register, the block turns N into an absolute cycle deadline within the frame. The deadline is (341*21 + 128 + 341*N) / 3, rounded down. The block computes this with a constant multiply, followed by a multiply by a reciprocal and a shift in place of a divider.

A separate control register carries an enable bit. The interrupt line rises once the counter has reached the armed deadline while that bit is set. It then stays high until software writes either register or the next frame begins. No scanline edges are detected. The trigger is purely an arithmetic cycle deadline. The host sees the block only through write cycles and the single interrupt line.

Top module: `line_irq_gen`

## Requirements
- R1: A write to address 0x5203 with data N drops any pending interrupt and any armed deadline. It arms a new deadline only when 1 <= N <= 239. N = 0 and N >= 240 leave nothing armed.
- R2: The deadline is D = floor((7289 + 341*N) / 3) counter cycles after frame start. With the enable set and N written in the first cycle after frame start, `irq` first reads high after D+1 rising edges following the edge that sampled `frame_start`. For example, N = 1 gives D = 2543 and N = 239 gives D = 29596.
- R3: A deadline that is earlier than the counter value at the moment of the write arms nothing. A deadline equal to the counter value does arm, and fires one cycle later.
- R4: A write to address 0x5204 stores the data byte as the control value and drops any pending interrupt. `irq` can be set only while bit 7 of the stored control value is 1.
- R5: A `frame_start` pulse resets the counter to zero and clears both the armed deadline and `irq`. If it coincides with a target write, no deadline is armed.
- R6: Once high, `irq` stays high until a write to 0x5203 or 0x5204, or a `frame_start` pulse.
- R7: A deadline that passes while bit 7 of the control value is 0 is used up. Setting bit 7 later in the same frame does not raise `irq`.
- R8: Writes to any other address, and cycles without `wr_en`, change neither `irq` nor the armed state.
- R9: After reset, `irq` is low and the control value is zero, so a deadline reached without a control write raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| irq | output | 1 | Interrupt request, active high |

## Verification
An error in the deadline arithmetic or in the counter shows up as `irq` rising a fixed number of cycles early or late. The cycle-exact comparison catches this on the first frame where the line is written. A wrongly kept or dropped armed flag shows up as an interrupt that appears after an out-of-range, late or disabled write, or that never appears at all. Such errors become visible within one deadline span of the write. A pending flag that is not cleared shows up one cycle after the clearing write or frame pulse, as `irq` still being high.

// File: rtl/line_irq_gen.sv
module line_irq_gen #(
  parameter int unsigned          ADDR_W      = 16,
  parameter int unsigned          DATA_W      = 8,
  parameter int unsigned          CNT_W       = 17,
  parameter logic [ADDR_W-1:0]    TARGET_ADDR = 16'h5203,
  parameter logic [ADDR_W-1:0]    CTRL_ADDR   = 16'h5204,
  parameter int unsigned          LINE_CYC    = 341,
  parameter int unsigned          LEAD_LINES  = 21,
  parameter int unsigned          LEAD_OFS    = 128,
  parameter int unsigned          LINE_LIMIT  = 240,
  parameter int unsigned          EN_BIT      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq
);
  localparam int unsigned RECIP_SH = CNT_W;
  localparam int unsigned RECIP    = ((1 << RECIP_SH) + 2) / 3;
  localparam int unsigned PROD_W   = CNT_W + RECIP_SH;
  localparam int unsigned LEAD_CYC = LINE_CYC * LEAD_LINES + LEAD_OFS;

  logic [CNT_W-1:0]  cnt_q, dl_q, raw_cyc, new_dl;
  logic [PROD_W-1:0] prod;
  logic [DATA_W-1:0] ctrl_q;
  logic              armed_q, pend_q;
  logic              tgt_wr, ctrl_wr, hit, line_ok;

  assign tgt_wr  = wr_en && (wr_addr == TARGET_ADDR);
  assign ctrl_wr = wr_en && (wr_addr == CTRL_ADDR);
  assign raw_cyc = CNT_W'(LEAD_CYC) + CNT_W'(LINE_CYC) * CNT_W'(wr_data);
  assign prod    = PROD_W'(raw_cyc) * PROD_W'(RECIP);
  assign new_dl  = CNT_W'(prod >> RECIP_SH);
  assign line_ok = (wr_data != '0) && (32'(wr_data) < LINE_LIMIT);
  assign hit     = armed_q && (cnt_q >= dl_q);
  assign irq     = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      dl_q    <= '0;
      ctrl_q  <= '0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (hit) begin
        armed_q <= 1'b0;
        if (ctrl_q[EN_BIT]) pend_q <= 1'b1;
      end
      if (ctrl_wr) begin
        ctrl_q <= wr_data;
        pend_q <= 1'b0;
      end
      if (tgt_wr) begin
        dl_q    <= new_dl;
        armed_q <= line_ok && (new_dl >= cnt_q);
        pend_q  <= 1'b0;
      end
      if (frame_start) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
        pend_q  <= 1'b0;
      end else if (cnt_q != '1) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

module line_irq_gen_chk #(
  parameter int unsigned       ADDR_W      = 16,
  parameter int unsigned       DATA_W      = 8,
  parameter int unsigned       CNT_W       = 17,
  parameter logic [ADDR_W-1:0] TARGET_ADDR = 16'h5203,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 16'h5204,
  parameter int unsigned       EN_BIT      = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              irq,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [DATA_W-1:0] ctrl_q,
  input logic              armed_q
);
  logic tw, cw;
  assign tw = wr_en && (wr_addr == TARGET_ADDR);
  assign cw = wr_en && (wr_addr == CTRL_ADDR);

  p_target_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tw |=> !irq);
  p_bad_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tw && (wr_data == '0 || wr_data >= 8'd240)) |=> !armed_q);
  p_ctrl_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cw |=> !irq);
  p_irq_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl_q[EN_BIT]);
  p_frame_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!irq && !armed_q && cnt_q == '0));
  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && cnt_q != '1) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !frame_start && !tw && !cw) |=> irq);
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !irq && !tw) |=> !irq);
endmodule

bind line_irq_gen line_irq_gen_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
  .TARGET_ADDR(TARGET_ADDR), .CTRL_ADDR(CTRL_ADDR), .EN_BIT(EN_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq), .cnt_q(cnt_q),
  .ctrl_q(ctrl_q), .armed_q(armed_q)
);

// File: tb/line_irq_gen_tb.sv
`timescale 1ns/1ps
module line_irq_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        irq;

  int total = 0;
  int bad = 0;
  int edges = 0;
  int e0 = 0;
  string tag = "R9";

  int m_cnt, m_dl, m_en;
  bit m_armed, m_pend;

  always #10 clk = ~clk;

  line_irq_gen u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
  );

  function automatic int dl_of(int n);
    return (341 * 21 + 128 + 341 * n) / 3;
  endfunction

  always @(posedge clk) begin
    edges++;
    if (!rst_n) begin
      m_cnt = 0; m_dl = 0; m_en = 0; m_armed = 0; m_pend = 0;
    end else begin
      bit n_armed, n_pend;
      int n_dl, n_en;
      n_armed = m_armed; n_pend = m_pend; n_dl = m_dl; n_en = m_en;
      if (m_armed && m_cnt >= m_dl) begin
        n_armed = 0;
        if (m_en >= 128) n_pend = 1;
      end
      if (wr_en && wr_addr == 16'h5204) begin
        n_en = wr_data; n_pend = 0;
      end
      if (wr_en && wr_addr == 16'h5203) begin
        n_dl = dl_of(wr_data);
        n_armed = (wr_data != 0) && (wr_data < 240) && (n_dl >= m_cnt);
        n_pend = 0;
      end
      if (frame_start) begin
        m_cnt = 0; n_armed = 0; n_pend = 0;
      end else if (m_cnt < 131071) begin
        m_cnt = m_cnt + 1;
      end
      m_armed = n_armed; m_pend = n_pend; m_dl = n_dl; m_en = n_en;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (irq !== m_pend) begin
        bad++;
        $display("FAIL %s cycle-compare edge=%0d irq actual=%0b expected=%0b",
                 tag, edges, irq, m_pend);
      end
    end
  end

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic frame();
    frame_start = 1'b1;
    @(posedge clk);
    #1 e0 = edges;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_irq(input int limit, output int since);
    for (int i = 0; i < limit && !irq; i++) @(negedge clk);
    since = edges - e0;
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=0", edges);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s;
    idle(3);
    chk(irq == 1'b0, "R9 reset irq", irq, 0);
    @(negedge clk) rst_n = 1'b1;
    frame(); wr_reg(16'h5203, 8'd1); idle(2700);
    chk(irq == 1'b0, "R9 disabled after reset", irq, 0);

    tag = "R2";
    wr_reg(16'h5204, 8'h80);
    frame(); wr_reg(16'h5203, 8'd1); wait_irq(3000, s);
    chk(s == 2544, "R2 N=1 fire edge", s, 2544);
    tag = "R6"; idle(50);
    chk(irq == 1'b1, "R6 hold", irq, 1);
    tag = "R8"; wr_reg(16'h5205, 8'h00); wr_reg(16'h5303, 8'd5);
    chk(irq == 1'b1, "R8 other address ignored", irq, 1);
    tag = "R4"; wr_reg(16'h5204, 8'h80);
    chk(irq == 1'b0, "R4 control write clears", irq, 0);

    tag = "R2";
    frame(); wr_reg(16'h5203, 8'd239); wait_irq(30000, s);
    chk(s == 29597, "R2 N=239 fire edge", s, 29597);
    tag = "R5"; frame();
    chk(irq == 1'b0, "R5 frame clears irq", irq, 0);

    tag = "R1";
    wr_reg(16'h5203, 8'd0); idle(3000);
    chk(irq == 1'b0, "R1 N=0 no arm", irq, 0);
    frame(); wr_reg(16'h5203, 8'd240); idle(30000);
    chk(irq == 1'b0, "R1 N=240 no arm", irq, 0);
    frame(); wr_reg(16'h5203, 8'd239); idle(100); wr_reg(16'h5203, 8'd255); idle(30000);
    chk(irq == 1'b0, "R1 rewrite drops deadline", irq, 0);

    tag = "R3";
    frame(); idle(3000); wr_reg(16'h5203, 8'd1); idle(200);
    chk(irq == 1'b0, "R3 late write no arm", irq, 0);
    frame();
    while (edges - e0 < 2543) @(negedge clk);
    wr_reg(16'h5203, 8'd1); wait_irq(100, s);
    chk(s == 2545, "R3 equal deadline fires", s, 2545);

    tag = "R5";
    frame(); wr_reg(16'h5203, 8'd1); idle(100); frame(); idle(3000);
    chk(irq == 1'b0, "R5 frame drops armed", irq, 0);

    tag = "R7";
    wr_reg(16'h5204, 8'h7f);
    frame(); wr_reg(16'h5203, 8'd1); idle(2700);
    chk(irq == 1'b0, "R7 masked while disabled", irq, 0);
    wr_reg(16'h5204, 8'h80); idle(200);
    chk(irq == 1'b0, "R7 no re-arm after enable", irq, 0);

    tag = "R8";
    frame(); wr_reg(16'h5303, 8'd1); idle(3000);
    chk(irq == 1'b0, "R8 wrong address no arm", irq, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule